// File: doc/BRIEF.md
# Remappable Interrupt Priority Encoder

This block gathers a bank of peripheral interrupt request lines and reduces them to one request for the processor: a 3-bit level and a vector number. Each source has a fixed level from 1 to 6 and a fixed priority within that level, both taken from a built-in table. Arbitration selects the pending source with the highest level. Among sources at that level, it selects the one with the highest priority. Level 0 on the output means that nothing is pending. Non-maskable level 7 requests are handled outside this block.

Two writable promotion registers each hold a source number. The source named in the first register takes the top maskable slot, level 6 priority 7. The source named in the second register takes the next slot, level 6 priority 6. A promoted source gives up its table slot for as long as it is promoted. A register value of 0 leaves its slot empty. Software can use this to move, for example, a serial receiver and transmitter ahead of every other maskable request.

Top module: `irq_prio_enc`

## Requirements
- R1: Source s (1..31) has default level 6-((s+1)>>3) and default priority 7-((s+1) mod 8). For example, source 16 has level 4 priority 6, and source 17 has level 4 priority 5.
- R2: While lvl_o is nonzero, vec_o equals the winning source number plus 64. While lvl_o is 0, vec_o is 0.
- R3: The winner is the pending source with the highest level, and among equal levels the one with the highest priority. When no source is pending, lvl_o is 0.
- R4: A pending source named by promotion register A (address 0) is reported at level 6 priority 7. It beats every other pending source.
- R5: A pending source named by promotion register B (address 1) is reported at level 6 priority 6. It beats every source except the one named by register A.
- R6: A promotion register holding 0 promotes nothing. Source line 0 is reserved and never raises a request.
- R7: While a source is promoted, it competes only in its promoted slot and never at its default level and priority.
- R8: When both registers name the same source, that source takes the register A slot (level 6 priority 7).
- R9: lvl_o and vec_o are registered. They reflect req_i as sampled at the previous rising clock edge. A register write takes effect in the arbitration at the edge after the edge that performs the write.
- R10: When wr_en_i is high, a rising edge writes the low 5 bits of wdata_i to the register selected by addr_i. rdata_o shows the selected register without delay, with bits 7:5 reading as 0.
- R11: While rst_ni is low, both registers are 0, and lvl_o and vec_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 32 | Interrupt request lines, one per source |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 1 | Register select: 0 = promotion A, 1 = promotion B |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data of the selected register |
| lvl_o | output | 3 | Level of the winning request, 0 when idle |
| vec_o | output | 8 | Vector number of the winning request |

## Verification
The checker watches four properties on every cycle:
- the vector is zero while the level is idle, and lies in the source range otherwise;
- the reported level never exceeds 6;
- an idle request bank, or a bank in which only the reserved line is active, yields level 0 one cycle later;
- a pending source named by promotion register A always appears one cycle later at level 6 with its own vector.

Other behaviours need the bench's scenarios and its slot-by-slot reference model, which is compared on every clock. These include the full default table, ordering between arbitrary mixes of sources, register B promotion, loss of the default slot, duplicate register values, and the one-cycle delay before a register write takes effect.

// File: rtl/irq_enc_pkg.sv
package irq_enc_pkg;
  localparam int LVL_W  = 3;
  localparam int PRIO_W = 3;
  localparam int RANK_W = LVL_W + PRIO_W;

  typedef logic [RANK_W-1:0] rank_t;

  localparam rank_t RANK_SLOT_A = {3'd6, 3'd7};
  localparam rank_t RANK_SLOT_B = {3'd6, 3'd6};
  localparam rank_t RANK_NONE   = '0;

  // table: eight slots per level, starting just under the two promoted slots
  function automatic logic [LVL_W-1:0] dflt_level(input int src);
    return LVL_W'(6 - ((src + 1) >> 3));
  endfunction

  function automatic logic [PRIO_W-1:0] dflt_prio(input int src);
    return PRIO_W'(7 - ((src + 1) & 7));
  endfunction

  function automatic rank_t dflt_rank(input int src);
    return {dflt_level(src), dflt_prio(src)};
  endfunction
endpackage

// File: rtl/irq_remap_regs.sv
module irq_remap_regs #(
  parameter int SRC_W  = 5,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [SRC_W-1:0]  remap_a_o,
  output logic [SRC_W-1:0]  remap_b_o
);
  logic [SRC_W-1:0] remap_q [2];

  for (genvar r = 0; r < 2; r++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                          remap_q[r] <= '0;
      else if (wr_en_i && (addr_i == 1'(r))) remap_q[r] <= wdata_i[SRC_W-1:0];
    end
  end

  always_comb begin
    rdata_o = '0;
    rdata_o[SRC_W-1:0] = remap_q[addr_i];
  end

  assign remap_a_o = remap_q[0];
  assign remap_b_o = remap_q[1];
endmodule

// File: rtl/irq_rank_map.sv
module irq_rank_map
  import irq_enc_pkg::*;
#(
  parameter int N_SRC = 32,
  parameter int SRC_W = 5
) (
  input  logic [N_SRC-1:0]             req_i,
  input  logic [SRC_W-1:0]             remap_a_i,
  input  logic [SRC_W-1:0]             remap_b_i,
  output logic [N_SRC-1:0][RANK_W-1:0] rank_o
);
  for (genvar s = 0; s < N_SRC; s++) begin : g_src
    if (s == 0) begin : g_rsvd
      assign rank_o[s] = RANK_NONE;
    end else begin : g_live
      localparam rank_t DFLT = dflt_rank(s);
      always_comb begin
        if (!req_i[s])                     rank_o[s] = RANK_NONE;
        else if (remap_a_i == SRC_W'(s))   rank_o[s] = RANK_SLOT_A;
        else if (remap_b_i == SRC_W'(s))   rank_o[s] = RANK_SLOT_B;
        else                               rank_o[s] = DFLT;
      end
    end
  end
endmodule

// File: rtl/irq_arb.sv
module irq_arb
  import irq_enc_pkg::*;
#(
  parameter int N_SRC = 32,
  parameter int SRC_W = 5
) (
  input  logic [N_SRC-1:0][RANK_W-1:0] rank_i,
  output logic                         valid_o,
  output logic [SRC_W-1:0]             idx_o,
  output logic [LVL_W-1:0]             level_o
);
  rank_t best;

  // ranks are unique per live source, so strict compare is enough
  always_comb begin
    best  = RANK_NONE;
    idx_o = '0;
    for (int s = 0; s < N_SRC; s++) begin
      if (rank_i[s] > best) begin
        best  = rank_i[s];
        idx_o = SRC_W'(s);
      end
    end
  end

  assign valid_o = (best != RANK_NONE);
  assign level_o = best[RANK_W-1 -: LVL_W];
endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc
  import irq_enc_pkg::*;
#(
  parameter int N_SRC    = 32,
  parameter int DATA_W   = 8,
  parameter int VEC_W    = 8,
  parameter int VEC_BASE = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_SRC-1:0]  req_i,
  input  logic              wr_en_i,
  input  logic              addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [LVL_W-1:0]  lvl_o,
  output logic [VEC_W-1:0]  vec_o
);
  localparam int SRC_W = $clog2(N_SRC);

  logic [SRC_W-1:0]             remap_a_q, remap_b_q;
  logic [N_SRC-1:0][RANK_W-1:0] rank;
  logic                         win_valid;
  logic [SRC_W-1:0]             win_idx;
  logic [LVL_W-1:0]             win_level;
  logic [LVL_W-1:0]             lvl_q;
  logic [VEC_W-1:0]             vec_q;

  irq_remap_regs #(.SRC_W(SRC_W), .DATA_W(DATA_W)) u_regs (
    .clk_i, .rst_ni, .wr_en_i, .addr_i, .wdata_i, .rdata_o,
    .remap_a_o(remap_a_q), .remap_b_o(remap_b_q)
  );

  irq_rank_map #(.N_SRC(N_SRC), .SRC_W(SRC_W)) u_map (
    .req_i, .remap_a_i(remap_a_q), .remap_b_i(remap_b_q), .rank_o(rank)
  );

  irq_arb #(.N_SRC(N_SRC), .SRC_W(SRC_W)) u_arb (
    .rank_i(rank), .valid_o(win_valid), .idx_o(win_idx), .level_o(win_level)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lvl_q <= '0;
      vec_q <= '0;
    end else if (win_valid) begin
      lvl_q <= win_level;
      vec_q <= VEC_W'(VEC_BASE) + VEC_W'(win_idx);
    end else begin
      lvl_q <= '0;
      vec_q <= '0;
    end
  end

  assign lvl_o = lvl_q;
  assign vec_o = vec_q;
endmodule

// File: rtl/irq_prio_enc_chk.sv
module irq_prio_enc_chk #(
  parameter int N_SRC    = 32,
  parameter int SRC_W    = 5,
  parameter int VEC_W    = 8,
  parameter int VEC_BASE = 64
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [N_SRC-1:0] req_i,
  input logic [2:0]       lvl_o,
  input logic [VEC_W-1:0] vec_o,
  input logic [SRC_W-1:0] remap_a
);
  p_vec_idle_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lvl_o == 3'd0) |-> (vec_o == '0));

  p_vec_range_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lvl_o != 3'd0) |-> (vec_o > VEC_W'(VEC_BASE) && vec_o < VEC_W'(VEC_BASE + N_SRC)));

  p_maskable_only_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lvl_o <= 3'd6);

  p_idle_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i[N_SRC-1:1] == '0) |=> (lvl_o == 3'd0));

  p_slot_a_wins_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (remap_a != '0 && req_i[remap_a])
      |=> (lvl_o == 3'd6 && vec_o == VEC_W'(VEC_BASE) + VEC_W'($past(remap_a))));
endmodule

bind irq_prio_enc irq_prio_enc_chk #(
  .N_SRC(N_SRC), .SRC_W(SRC_W), .VEC_W(VEC_W), .VEC_BASE(VEC_BASE)
) u_chk (
  .clk_i, .rst_ni, .req_i, .lvl_o, .vec_o, .remap_a(remap_a_q)
);

// File: tb/irq_prio_enc_tb.sv
module irq_prio_enc_tb;
  localparam int CLK_PERIOD = 10;
  localparam int N = 32;

  logic        clk = 0;
  logic        rst_n = 0;
  logic [N-1:0] req = '0;
  logic        wr_en = 0;
  logic        addr = 0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic [2:0]  lvl;
  logic [7:0]  vec;

  int n_chk = 0;
  int n_err = 0;
  string tag = "R11";

  irq_prio_enc u_dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .wr_en_i(wr_en), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .lvl_o(lvl), .vec_o(vec)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // reference model: a slot lookup per source, scanned from the top slot down
  int ma = 0, mb = 0;
  int exp_lvl = 0, exp_vec = 0;

  function automatic int ref_lvl(int s);
    if (s <= 6) return 6;
    if (s <= 14) return 5;
    if (s <= 22) return 4;
    if (s <= 30) return 3;
    return 2;
  endfunction

  function automatic void slot_of(int s, int a, int b, output int l, output int p);
    if (s == a) begin l = 6; p = 7; end
    else if (s == b) begin l = 6; p = 6; end
    else begin l = ref_lvl(s); p = 7 - ((s + 1) % 8); end
  endfunction

  function automatic int pick(logic [N-1:0] r, int a, int b);
    for (int l = 6; l >= 1; l--)
      for (int p = 7; p >= 0; p--)
        for (int s = 1; s < N; s++) begin
          int sl, sp;
          slot_of(s, a, b, sl, sp);
          if (r[s] && sl == l && sp == p) return s;
        end
    return -1;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ma <= 0; mb <= 0; exp_lvl <= 0; exp_vec <= 0;
    end else begin
      int w, wl, wp;
      w = pick(req, ma, mb);
      if (w < 0) begin exp_lvl <= 0; exp_vec <= 0; end
      else begin
        slot_of(w, ma, mb, wl, wp);
        exp_lvl <= wl; exp_vec <= w + 64;
      end
      if (wr_en) begin
        if (addr) mb <= int'(wdata[4:0]); else ma <= int'(wdata[4:0]);
      end
    end
  end

  // per-cycle compare, away from the active edge (R9 timing)
  always @(negedge clk) begin
    n_chk++;
    if (int'(lvl) != exp_lvl || int'(vec) != exp_vec) begin
      n_err++;
      $display("FAIL %s: lvl=%0d vec=%0d expected lvl=%0d vec=%0d",
               tag, lvl, vec, exp_lvl, exp_vec);
    end
  end

  task automatic step(int n = 1);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wr(logic a, logic [7:0] d);
    wr_en = 1; addr = a; wdata = d;
    step();
    wr_en = 0;
  endtask

  task automatic rd_check(logic a, int exp, string t);
    addr = a;
    #1;
    n_chk++;
    if (int'(rdata) != exp) begin
      n_err++;
      $display("FAIL %s: rdata=%0d expected %0d", t, rdata, exp);
    end
  endtask

  task automatic apply(logic [N-1:0] r, string t);
    tag = t; req = r;
    step(2);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_err++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    $finish;
  end

  initial begin
    tag = "R11";
    step(3);
    rd_check(0, 0, "R11"); rd_check(1, 0, "R11");
    rst_n = 1;
    step(2);

    // R1 and R2: each source alone
    for (int s = 1; s < N; s++) apply(N'(1) << s, "R1");
    apply('0, "R3");
    apply(N'(1), "R6");  // reserved line
    // R3: mixed patterns
    apply((N'(1) << 16) | (N'(1) << 17), "R3");
    apply((N'(1) << 22) | (N'(1) << 23), "R3");
    apply((N'(1) << 6) | (N'(1) << 7) | (N'(1) << 31), "R3");
    apply((N'(1) << 30) | (N'(1) << 31), "R3");
    for (int i = 0; i < 40; i++) apply(N'($urandom), "R3");

    // R10: register access
    tag = "R10";
    wr(0, 8'hF0);
    rd_check(0, 8'h10, "R10");
    wr(1, 8'h11);
    rd_check(1, 8'h11, "R10"); rd_check(0, 8'h10, "R10");

    // R4, R5: promoted sources outrank everything
    apply((N'(1) << 16) | (N'(1) << 1), "R4");
    apply((N'(1) << 17) | (N'(1) << 1), "R5");
    apply((N'(1) << 16) | (N'(1) << 17) | N'(126), "R4");
    // R7: promoted source absent from its default slot
    apply((N'(1) << 17) | (N'(1) << 15), "R7");
    for (int i = 0; i < 30; i++) apply(N'($urandom), "R7");

    // R9: write while requests pending; the change shows one edge later
    tag = "R9";
    req = (N'(1) << 3) | (N'(1) << 25);
    wr(0, 8'd25);
    step(2);

    // R8: both registers name one source
    wr(1, 8'd25);
    apply(N'(1) << 25, "R8");
    apply((N'(1) << 25) | (N'(1) << 2), "R8");

    // R6: zero means no promotion
    wr(0, 8'd0); wr(1, 8'd0);
    rd_check(0, 0, "R6");
    apply((N'(1) << 16) | (N'(1) << 17), "R6");
    for (int i = 0; i < 20; i++) apply(N'($urandom), "R6");

    // R11: reset in mid-traffic
    wr(0, 8'd9);
    req = '1;
    tag = "R11";
    rst_n = 0;
    #1;
    n_chk++;
    if (lvl != 0 || vec != 0 || rdata != 0) begin
      n_err++;
      $display("FAIL R11: lvl=%0d vec=%0d rdata=%0d expected 0 0 0", lvl, vec, rdata);
    end
    step(2);
    rst_n = 1;
    apply(N'(1) << 9, "R11");

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    $finish;
  end
endmodule